// File: doc/BRIEF.md
# PC Card 16-bit Access Strobe Sequencer

This block turns one internal access request into the timed control strobes of an 8-bit or 16-bit PC Card socket. A request carries a word address, two byte enables, a read/write flag, a memory/I-O flag and an attribute/common flag. The block drives the address, both card enables, the memory read and write strobes, the I/O read and write strobes and the space-select line. It returns read data with a one-clock completion pulse.

Every access runs through a fixed sequence: a setup phase with the address and enables valid, a strobe phase of programmable length that the card can stretch with its hold input, and a hold phase with the enables still valid. Byte-lane steering follows the card width. A 16-bit path uses one enable per byte. An 8-bit path uses only the even enable and carries the selected byte on the low data lane, with address bit 0 naming it. For I/O accesses the card's 16-bit indication picks the path. The block also drives the card reset line, whose output enable stays off until the socket is qualified.

Top module: `pccard_strobe_gen`

## Requirements
- R1: The 16-bit path is used for memory accesses when `card_wide`=1, and for I/O accesses when `card_wide`=1 and `card_io_wide_n`=0. On it, `card_en_even_n`=~`req_be[0]` and `card_en_odd_n`=~`req_be[1]` (req_be bit 0 = even byte, bit 1 = odd byte), `card_addr[0]`=0, and data passes straight through in both directions.
- R2: On the 8-bit path `card_en_odd_n` stays high for the whole access and `card_en_even_n` is low. With `req_be`=2'b10 the odd byte moves: `card_addr[0]`=1, write byte `req_wdata[15:8]` goes out on `card_wdata[7:0]`, and read byte `card_rdata[7:0]` lands in `rd_data[15:8]`. With any other enable pattern the even byte moves: `card_addr[0]`=0, using lane [7:0] on both sides. Unused lanes read as zero.
- R3: During the strobe phase of a memory access `mem_rd_n` is low for a read and `mem_wr_n` is low for a write. At most one of the four strobes is low at any time.
- R4: During the strobe phase of an I/O access `io_rd_n` is low for a read and `io_wr_n` is low for a write. No strobe is low in the setup or hold phase.
- R5: While busy, `space_sel_n` is 0 for attribute memory (`req_attr`=1), 1 for common memory, and 0 for every I/O access. While idle it is 1.
- R6: When `card_hold_n` is sampled low at the edge where the strobe would end, the strobe stays active one more clock. Holding it low earlier in the strobe phase does not lengthen the strobe.
- R7: `card_io_wide_n` is sampled only at the clock that accepts the request. Later changes do not alter the lane mode of that access.
- R8: `card_rst_oe` is 1 one clock after `card_present`, `card_pwr_on` and `card_if_en` are all 1, and 0 one clock after any of them is 0. While enabled, `card_rst` follows `card_reset_req` one clock later; otherwise it is 0.
- R9: After acceptance the access spends exactly 2 setup clocks, then max(`strobe_len`,3) strobe clocks plus any hold extension, then exactly 1 hold clock, then returns to idle.
- R10: `done` is high for exactly one clock: the hold clock. `rd_data` holds the data captured at the edge that ends the strobe, and is valid while `done` is high.
- R11: `req_valid` is sampled only while idle. A request raised during a busy access is ignored: the access in flight keeps its address, and no second access follows once the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_word | input | ADDR_W-1 | Word address of the access |
| req_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_attr | input | 1 | 1 = attribute memory, 0 = common memory |
| req_wdata | input | 16 | Write data, byte lanes as on the request side |
| strobe_len | input | LEN_W | Programmed strobe length in clocks, clamped to at least 3 |
| card_wide | input | 1 | 1 = the card has a 16-bit data path |
| card_hold_n | input | 1 | Card hold request, active low |
| card_io_wide_n | input | 1 | Card reports a 16-bit I/O location, active low |
| card_rdata | input | 16 | Card data bus input |
| card_present | input | 1 | Card seated in the socket |
| card_pwr_on | input | 1 | Socket power applied |
| card_if_en | input | 1 | Card interface signals enabled |
| card_reset_req | input | 1 | Requested card reset level |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| card_addr | output | ADDR_W | Card address, bit 0 from lane steering |
| card_en_even_n | output | 1 | Even-byte card enable, active low |
| card_en_odd_n | output | 1 | Odd-byte card enable, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| space_sel_n | output | 1 | Low selects attribute memory or an I/O access |
| card_wdata | output | 16 | Card data bus output |
| card_wdata_oe | output | 1 | Drive enable for card_wdata |
| card_rst | output | 1 | Card reset level, active high |
| card_rst_oe | output | 1 | Drive enable for card_rst (off = high impedance) |

## Verification
The bench builds the block with ADDR_W=8 and LEN_W=3, so every strobe length from below the minimum up to the 3-bit ceiling of 7 can be reached in a few clocks. A single sweep crosses read/write, memory/I-O, attribute/common, card width, the 16-bit I/O indication and all three non-empty byte-enable patterns. It does so at several strobe lengths and hold extensions, so both lane paths, every strobe kind and the clamp are covered in every combination. The expected phase lengths, lane placement and data are computed arithmetically from those inputs. All eight socket-qualification combinations are swept for the reset gate.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } pcs_phase_e;

  typedef struct packed {
    logic       write;
    logic       io;
    logic       attr;
    logic       path16;
    logic [1:0] be;
  } pcs_cmd_t;

  // 16-bit path selection: memory follows the card width, I/O also needs
  // the card's per-location wide indication.
  function automatic logic pick_path16(input logic io, input logic wide,
                                       input logic io_wide_n);
    return io ? (wide & ~io_wide_n) : wide;
  endfunction

  // The odd byte moves on its own over the narrow path only when it alone is enabled.
  function automatic logic narrow_odd(input logic path16, input logic [1:0] be);
    return ~path16 & (be == 2'b10);
  endfunction

  // Active-high lane enables {odd, even}.
  function automatic logic [1:0] lane_enables(input logic path16, input logic [1:0] be);
    return path16 ? be : 2'b01;
  endfunction

  function automatic logic [DATA_W-1:0] steer_write(input logic path16,
      input logic [1:0] be, input logic [DATA_W-1:0] d);
    logic [BYTE_W-1:0] sel;
    sel = narrow_odd(path16, be) ? d[DATA_W-1:BYTE_W] : d[BYTE_W-1:0];
    return path16 ? d : {{BYTE_W{1'b0}}, sel};
  endfunction

  function automatic logic [DATA_W-1:0] steer_read(input logic path16,
      input logic [1:0] be, input logic [DATA_W-1:0] d);
    if (path16) return d;
    if (narrow_odd(path16, be)) return {d[BYTE_W-1:0], {BYTE_W{1'b0}}};
    return {{BYTE_W{1'b0}}, d[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/pcs_seq.sv
module pcs_seq
  import pcs_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int HOLD_CLKS  = 1,
  parameter int STROBE_MIN = 3,
  parameter int LEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold_n,
  input  logic [LEN_W-1:0] len_cfg,
  output pcs_phase_e       phase,
  output logic             strobe_end,
  output logic             hold_last,
  output logic             len_met
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CLKS - 1);
  localparam logic [LEN_W-1:0] LEN_FLOOR  = LEN_W'(STROBE_MIN);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v < LEN_FLOOR) ? LEN_FLOOR : v;
  endfunction

  pcs_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] eff_q;
  logic             setup_last;

  assign setup_last = (cnt_q == SETUP_LAST);
  assign len_met    = ((cnt_q + CNT_W'(1)) >= {1'b0, eff_q});
  assign strobe_end = (phase_q == PH_STROBE) && len_met && hold_n;
  assign hold_last  = (phase_q == PH_HOLD) && (cnt_q == HOLD_LAST);
  assign phase      = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_SETUP;
        cnt_d   = '0;
      end
      PH_SETUP: if (setup_last) begin
        phase_d = PH_STROBE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      PH_STROBE: if (strobe_end) begin
        phase_d = PH_HOLD;
        cnt_d   = '0;
      end else if (!len_met) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      PH_HOLD: if (hold_last) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      eff_q   <= LEN_FLOOR;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (start) eff_q <= clamp_len(len_cfg);
    end
  end

endmodule

// File: rtl/pcs_lanes.sv
module pcs_lanes
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-2:0] word,
  input  logic [1:0]        be,
  input  logic              write,
  input  logic              io,
  input  logic              attr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wide,
  input  logic              io_wide_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] card_rdata,
  output pcs_cmd_t          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        lane_en,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [DATA_W-1:0] rd_data
);

  pcs_cmd_t          cmd_q;
  logic [ADDR_W-2:0] word_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic              path16_new;
  logic [1:0]        en_raw;

  assign path16_new = pick_path16(io, wide, io_wide_n);
  assign en_raw     = lane_enables(cmd_q.path16, cmd_q.be);

  // one enable per byte lane
  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_en[l] = en_raw[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (load) begin
        cmd_q.write  <= write;
        cmd_q.io     <= io;
        cmd_q.attr   <= attr;
        cmd_q.path16 <= path16_new;
        cmd_q.be     <= be;
        word_q       <= word;
        wdata_q      <= steer_write(path16_new, be, wdata);
      end
      if (capture && !cmd_q.write)
        rd_q <= steer_read(cmd_q.path16, cmd_q.be, card_rdata);
    end
  end

  assign cmd        = cmd_q;
  assign addr       = {word_q, narrow_odd(cmd_q.path16, cmd_q.be)};
  assign lane_wdata = wdata_q;
  assign rd_data    = rd_q;

endmodule

// File: rtl/pcs_rst_gate.sv
module pcs_rst_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic pwr_on,
  input  logic if_en,
  input  logic reset_req,
  output logic qualified,
  output logic rst_lvl,
  output logic rst_oe
);

  assign qualified = present & pwr_on & if_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_oe  <= 1'b0;
      rst_lvl <= 1'b0;
    end else begin
      rst_oe  <= qualified;
      rst_lvl <= qualified & reset_req;
    end
  end

endmodule

// File: rtl/pccard_strobe_gen.sv
module pccard_strobe_gen
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LEN_W      = 4,
  parameter int SETUP_CLKS = 2,
  parameter int HOLD_CLKS  = 1,
  parameter int STROBE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-2:0] req_word,
  input  logic [1:0]        req_be,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_attr,
  input  logic [15:0]       req_wdata,
  input  logic [LEN_W-1:0]  strobe_len,
  input  logic              card_wide,
  input  logic              card_hold_n,
  input  logic              card_io_wide_n,
  input  logic [15:0]       card_rdata,
  input  logic              card_present,
  input  logic              card_pwr_on,
  input  logic              card_if_en,
  input  logic              card_reset_req,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_en_even_n,
  output logic              card_en_odd_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              space_sel_n,
  output logic [15:0]       card_wdata,
  output logic              card_wdata_oe,
  output logic              card_rst,
  output logic              card_rst_oe
);

  pcs_phase_e phase;
  pcs_cmd_t   cmd;
  logic       start, strobe_end, hold_last, len_met;
  logic       active, strobing;
  logic [1:0] lane_en;
  // event wires brought out for the checker
  logic       path16;
  logic       rst_qual;

  assign start = req_valid && (phase == PH_IDLE);

  pcs_seq #(
    .SETUP_CLKS(SETUP_CLKS),
    .HOLD_CLKS (HOLD_CLKS),
    .STROBE_MIN(STROBE_MIN),
    .LEN_W     (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hold_n    (card_hold_n),
    .len_cfg   (strobe_len),
    .phase     (phase),
    .strobe_end(strobe_end),
    .hold_last (hold_last),
    .len_met   (len_met)
  );

  pcs_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .word      (req_word),
    .be        (req_be),
    .write     (req_write),
    .io        (req_io),
    .attr      (req_attr),
    .wdata     (req_wdata),
    .wide      (card_wide),
    .io_wide_n (card_io_wide_n),
    .capture   (strobe_end),
    .card_rdata(card_rdata),
    .cmd       (cmd),
    .addr      (card_addr),
    .lane_en   (lane_en),
    .lane_wdata(card_wdata),
    .rd_data   (rd_data)
  );

  pcs_rst_gate u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .present  (card_present),
    .pwr_on   (card_pwr_on),
    .if_en    (card_if_en),
    .reset_req(card_reset_req),
    .qualified(rst_qual),
    .rst_lvl  (card_rst),
    .rst_oe   (card_rst_oe)
  );

  assign path16   = cmd.path16;
  assign active   = (phase != PH_IDLE);
  assign strobing = (phase == PH_STROBE);

  assign busy           = active;
  assign done           = hold_last;
  assign card_en_even_n = ~(active & lane_en[0]);
  assign card_en_odd_n  = ~(active & lane_en[1]);
  assign mem_rd_n       = ~(strobing & ~cmd.io & ~cmd.write);
  assign mem_wr_n       = ~(strobing & ~cmd.io &  cmd.write);
  assign io_rd_n        = ~(strobing &  cmd.io & ~cmd.write);
  assign io_wr_n        = ~(strobing &  cmd.io &  cmd.write);
  assign space_sel_n    = ~(active & (cmd.io | cmd.attr));
  assign card_wdata_oe  = active & cmd.write;

  // len_met is consumed by the sequencer; keep it visible at this level
  logic len_met_seen;
  assign len_met_seen = len_met;

endmodule

// File: rtl/pccard_strobe_gen_chk.sv
module pccard_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic card_en_odd_n,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic io_rd_n,
  input logic io_wr_n,
  input logic card_hold_n,
  input logic path16,
  input logic rst_qual,
  input logic card_rst_oe,
  input logic len_met_seen
);

  logic strobe_any;
  assign strobe_any = ~(mem_rd_n & mem_wr_n & io_rd_n & io_wr_n);

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n})); // R3

  AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> busy); // R4

  AST_NARROW_NO_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !path16 |-> card_en_odd_n); // R2

  AST_HOLD_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any && !card_hold_n |=> strobe_any); // R6

  AST_EARLY_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any && !len_met_seen |=> strobe_any); // R9

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_any) |-> $past(busy) && $past(busy, 2) && !$past(strobe_any)); // R9

  AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_any) |-> $past(strobe_any, 2) && $past(strobe_any, 3)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(strobe_any) && !strobe_any); // R10

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_qual |=> !card_rst_oe); // R8

endmodule

bind pccard_strobe_gen pccard_strobe_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .card_en_odd_n(card_en_odd_n),
  .mem_rd_n     (mem_rd_n),
  .mem_wr_n     (mem_wr_n),
  .io_rd_n      (io_rd_n),
  .io_wr_n      (io_wr_n),
  .card_hold_n  (card_hold_n),
  .path16       (path16),
  .rst_qual     (rst_qual),
  .card_rst_oe  (card_rst_oe),
  .len_met_seen (len_met_seen)
);

// File: tb/pccard_strobe_gen_tb.sv
`timescale 1ns/1ps
module pccard_strobe_gen_tb;

  localparam int ADDR_W = 8;
  localparam int LEN_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-2:0] req_word = '0;
  logic [1:0]        req_be = 2'b00;
  logic              req_write = 1'b0, req_io = 1'b0, req_attr = 1'b0;
  logic [15:0]       req_wdata = '0;
  logic [LEN_W-1:0]  strobe_len = '0;
  logic              card_wide = 1'b0, card_hold_n = 1'b1, card_io_wide_n = 1'b1;
  logic [15:0]       card_rdata = '0;
  logic              card_present = 1'b0, card_pwr_on = 1'b0, card_if_en = 1'b0;
  logic              card_reset_req = 1'b0;
  logic              busy, done, card_en_even_n, card_en_odd_n;
  logic              mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, space_sel_n;
  logic              card_wdata_oe, card_rst, card_rst_oe;
  logic [15:0]       rd_data, card_wdata;
  logic [ADDR_W-1:0] card_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pccard_strobe_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
  endfunction

  // one full access, expectations restated from the requirements
  task automatic run_access(input bit wr, input bit io, input bit attr, input bit wide,
                            input bit iow_n, input logic [1:0] be, input int len,
                            input int wt, input int seed);
    bit   p16, odd, lanes_ok, kind_ok, reg_ok, wd_ok;
    int   eff, n_setup, n_str, n_hold, n_done, done_at_hold;
    logic [3:0] exp_str;
    logic [15:0] wd, rd_src, exp_rd, exp_wd;
    logic [ADDR_W-2:0] word;
    string ltag;
    word   = (ADDR_W-1)'(seed * 37 + 5);
    wd     = 16'(seed * 1543 + 16'h1234);
    rd_src = 16'(seed * 2719 + 16'h0BAD);
    p16    = io ? (wide && !iow_n) : wide;
    odd    = !p16 && (be == 2'b10);
    eff    = (len < 3) ? 3 : len;
    exp_str = 4'b1111;
    exp_str[{io, wr}] = 1'b0;              // index: memrd=0 memwr=1 iord=2 iowr=3
    exp_wd = p16 ? wd : {8'h00, odd ? wd[15:8] : wd[7:0]};
    exp_rd = p16 ? rd_src : (odd ? {rd_src[7:0], 8'h00} : {8'h00, rd_src[7:0]});
    ltag   = p16 ? (io ? "R1/R7" : "R1") : (io ? "R2/R7" : "R2");

    @(negedge clk);
    req_word = word; req_be = be; req_write = wr; req_io = io; req_attr = attr;
    req_wdata = wd; strobe_len = LEN_W'(len); card_wide = wide;
    card_io_wide_n = iow_n; card_rdata = rd_src; card_hold_n = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    card_io_wide_n = ~iow_n;               // R7: flipping after acceptance must not matter
    lanes_ok = 1; kind_ok = 1; reg_ok = 1; wd_ok = 1;
    n_setup = 0; n_str = 0; n_hold = 0; n_done = 0; done_at_hold = 0;
    for (int t = 0; t < 64 && busy; t++) begin
      if (card_en_even_n !== !(p16 ? be[0] : 1'b1)) lanes_ok = 0;
      if (card_en_odd_n  !== !(p16 ? be[1] : 1'b0)) lanes_ok = 0;
      if (card_addr !== {word, odd}) lanes_ok = 0;
      if (space_sel_n !== !(io || attr)) reg_ok = 0;
      if (wr && (card_wdata !== exp_wd || card_wdata_oe !== 1'b1)) wd_ok = 0;
      if (!wr && card_wdata_oe !== 1'b0) wd_ok = 0;
      if (strobes() != 4'b1111) begin
        n_str++;
        if (strobes() !== exp_str) kind_ok = 0;
        card_hold_n = (n_str >= eff + wt);
      end else begin
        card_hold_n = 1'b1;
        if (n_str == 0) n_setup++;
        else begin
          n_hold++;
          if (done) begin
            done_at_hold = 1;
            if (!wr) chk(rd_data === exp_rd, {"R10 ", ltag}, "read data", rd_data, exp_rd);
          end
        end
      end
      if (done) n_done++;
      @(negedge clk);
    end
    card_hold_n = 1'b1;
    chk(n_setup == 2, "R9", "setup clocks", n_setup, 2);
    chk(n_str == eff + wt, (wt > 0) ? "R6" : "R9", "strobe clocks", n_str, eff + wt);
    chk(n_hold == 1, "R9", "hold clocks", n_hold, 1);
    chk(n_done == 1 && done_at_hold == 1, "R10", "done pulse", n_done, 1);
    chk(lanes_ok, ltag, "lane enables/address", {card_en_odd_n, card_en_even_n}, 0);
    chk(kind_ok, io ? "R4" : "R3", "strobe kind", strobes(), exp_str);
    chk(reg_ok, "R5", "space select while busy", space_sel_n, !(io || attr));
    chk(wd_ok, ltag, "write lane data", card_wdata, exp_wd);
    chk(!busy && strobes() == 4'b1111 && space_sel_n && card_en_even_n && card_en_odd_n,
        "R5", "idle state after access", {busy, strobes(), space_sel_n}, 6'h1f);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seed;
    logic [ADDR_W-1:0] a_keep;
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !done && strobes() == 4'b1111, "R4", "reset strobes", strobes(), 4'hf);
    chk(card_en_even_n && card_en_odd_n && space_sel_n, "R5", "reset enables",
        {card_en_even_n, card_en_odd_n, space_sel_n}, 3'h7);
    chk(rd_data == 16'h0 && !card_rst_oe && !card_rst, "R8", "reset outputs",
        {rd_data, card_rst_oe, card_rst}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main sweep
    seed = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int io = 0; io < 2; io++)
        for (int at = 0; at < 2; at++)
          for (int wd = 0; wd < 2; wd++)
            for (int iw = 0; iw < 2; iw++)
              for (int be = 1; be < 4; be++)
                for (int li = 0; li < 4; li++) begin
                  int lens[4] = '{0, 2, 4, 7};
                  seed++;
                  run_access(wr[0], io[0], at[0], wd[0], iw[0], be[1:0], lens[li],
                             seed % 3, seed);
                end

    // R11: a request during a busy access is ignored
    @(negedge clk);
    req_word = 7'h2A; req_be = 2'b11; req_write = 1'b0; req_io = 1'b0; req_attr = 1'b0;
    strobe_len = 3'd3; card_wide = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    a_keep = card_addr;
    @(negedge clk);
    req_word = 7'h15; req_write = 1'b1; req_io = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(card_addr === a_keep && io_wr_n && !mem_rd_n, "R11", "in-flight access altered",
        card_addr, a_keep);
    while (busy) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(!busy, "R11", "second access started", busy, 0);
    end

    // R8: reset gate over all qualification combinations
    for (int q = 0; q < 8; q++)
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        {card_present, card_pwr_on, card_if_en} = q[2:0];
        card_reset_req = r[0];
        @(negedge clk);
        chk(card_rst_oe === (q == 7), "R8", "reset drive enable", card_rst_oe, q == 7);
        chk(card_rst === ((q == 7) && r == 1), "R8", "reset level", card_rst,
            (q == 7) && r == 1);
      end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule